// File: doc/BRIEF.md
# Programmable Panel Control Pulse Generator

This block derives one general-purpose panel timing output from the shared line and pixel counters of a display timing controller. Typical uses are a row-driver shift clock, a blanking-gated strobe, or a polarity reversal signal. Two windows are involved. A horizontal window covers a programmable range of the internal (half-rate) pixel count. A vertical window covers a programmable range of lines. A small control register chooses how the two windows merge, whether the result is inverted, and whether it flips polarity on alternate frames.

Each window is set by a start value and a length. The horizontal start is 10 bits and its length is 11 bits. The vertical start and length are both 11 bits. The output is registered, so it follows the counters with one clock of latency. A frame-start strobe toggles an internal frame-parity bit. When alternation is selected, that bit is folded into the output, which makes a signal that reverses polarity on every frame.

Top module: `panel_gpo_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `gpo_out` is 0 and the frame parity is 0.
- R2: The horizontal window is active when `pix_start <= pix_cnt < pix_start + pix_len`. The sum is computed without wrap-around.
- R3: The vertical window is active when `line_start <= line_cnt < line_start + line_len`. The sum is computed without wrap-around.
- R4: `ctrl[1:0]` selects how the windows are merged: 00 gives horizontal AND vertical, 01 gives horizontal only, 10 gives vertical only, and 11 gives horizontal XOR vertical.
- R5: When `ctrl[2]` is 1, the merged level is inverted.
- R6: Each cycle with `frame_start` high toggles the frame parity, starting from 0 at reset. The toggle takes effect in the next cycle. When `ctrl[3]` is 1, the output level is XORed with the frame parity.
- R7: When `ctrl[4]` is 0, `gpo_out` is 0 whatever the other inputs are.
- R8: `gpo_out` is registered. In the cycle after a clock edge, it shows the function of the inputs and the parity as they were sampled at that edge.
- R9: A window length of 0 keeps that window inactive for every count value.
- R10: A window whose end lies past the largest count value is active from its start up to the largest count. It does not wrap around to count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_cnt | input | 10 | Internal pixel count within the line |
| line_cnt | input | 11 | Line count within the frame |
| pix_start | input | 10 | Horizontal window start |
| pix_len | input | 11 | Horizontal window length in pixel counts |
| line_start | input | 11 | Vertical window start line |
| line_len | input | 11 | Vertical window length in lines |
| ctrl | input | 5 | [1:0] merge select, [2] invert, [3] frame alternation, [4] output enable |
| gpo_out | output | 1 | Registered control output |

## Verification
The bench builds the block with its default widths: a 10-bit pixel count and an 11-bit line count. With these widths, the top pixel value 1023 can be reached directly. That exposes a horizontal window whose end runs past the count range, which must not wrap to zero. Small rasters a few pixels wide and a few lines tall let the bench run several frames in a short time. Over those frames it covers each merge mode, inversion, frame alternation across strobes, zero-length windows and the enable gate.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic [1:0] {
        CMB_BOTH  = 2'b00,
        CMB_HORIZ = 2'b01,
        CMB_VERT  = 2'b10,
        CMB_DIFF  = 2'b11
    } combine_e;

    // Field layout of the 5-bit control word (bit 4 down to bit 0)
    typedef struct packed {
        logic     enable;
        logic     alternate;
        logic     invert;
        combine_e combine;
    } ctrl_t;

    typedef struct packed {
        logic odd;
    } parity_st_t;

    typedef struct packed {
        logic level;
    } out_st_t;

endpackage

// File: rtl/pcg_window.sv
module pcg_window #(
    parameter int CNT_W   = 10,
    parameter int START_W = 10,
    parameter int LEN_W   = 11
) (
    input  logic [CNT_W-1:0]   cnt,
    input  logic [START_W-1:0] start,
    input  logic [LEN_W-1:0]   len,
    output logic               active
);
    localparam int WIDEST = (START_W > LEN_W) ? START_W : LEN_W;
    localparam int MAXW   = (WIDEST > CNT_W) ? WIDEST : CNT_W;
    localparam int CMP_W  = MAXW + 1;

    logic [CMP_W-1:0] cnt_x;
    logic [CMP_W-1:0] lo_x;
    logic [CMP_W-1:0] hi_x;

    always_comb begin
        cnt_x  = CMP_W'(cnt);
        lo_x   = CMP_W'(start);
        hi_x   = lo_x + CMP_W'(len);
        active = (cnt_x >= lo_x) && (cnt_x < hi_x);
    end
endmodule

// File: rtl/pcg_parity.sv
module pcg_parity
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic odd
);
    parity_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.odd = ~st_q.odd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign odd = st_q.odd;
endmodule

// File: rtl/pcg_merge.sv
module pcg_merge
    import pcg_pkg::*;
(
    input  logic  horiz,
    input  logic  vert,
    input  ctrl_t ctrl,
    input  logic  odd,
    output logic  level
);
    logic merged;

    always_comb begin
        unique case (ctrl.combine)
            CMB_BOTH:  merged = horiz & vert;
            CMB_HORIZ: merged = horiz;
            CMB_VERT:  merged = vert;
            CMB_DIFF:  merged = horiz ^ vert;
            default:   merged = 1'b0;
        endcase
        level = ctrl.enable & (merged ^ ctrl.invert ^ (ctrl.alternate & odd));
    end
endmodule

// File: rtl/panel_gpo_gen.sv
module panel_gpo_gen
    import pcg_pkg::*;
#(
    parameter int PIX_CNT_W   = 10,
    parameter int PIX_START_W = 10,
    parameter int PIX_LEN_W   = 11,
    parameter int LINE_W      = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic [PIX_CNT_W-1:0]   pix_cnt,
    input  logic [LINE_W-1:0]      line_cnt,
    input  logic [PIX_START_W-1:0] pix_start,
    input  logic [PIX_LEN_W-1:0]   pix_len,
    input  logic [LINE_W-1:0]      line_start,
    input  logic [LINE_W-1:0]      line_len,
    input  logic [4:0]             ctrl,
    output logic                   gpo_out
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t   ctrl_s;
    logic    h_win;
    logic    v_win;
    logic    frame_odd;
    logic    level;
    out_st_t st_d, st_q;

    assign ctrl_s = ctrl_t'(ctrl[CTRL_W-1:0]);

    pcg_window #(
        .CNT_W  (PIX_CNT_W),
        .START_W(PIX_START_W),
        .LEN_W  (PIX_LEN_W)
    ) u_hwin (
        .cnt   (pix_cnt),
        .start (pix_start),
        .len   (pix_len),
        .active(h_win)
    );

    pcg_window #(
        .CNT_W  (LINE_W),
        .START_W(LINE_W),
        .LEN_W  (LINE_W)
    ) u_vwin (
        .cnt   (line_cnt),
        .start (line_start),
        .len   (line_len),
        .active(v_win)
    );

    pcg_parity u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .odd        (frame_odd)
    );

    pcg_merge u_mrg (
        .horiz(h_win),
        .vert (v_win),
        .ctrl (ctrl_s),
        .odd  (frame_odd),
        .level(level)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gpo_out = st_q.level;
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
    parameter int PIX_CNT_W   = 10,
    parameter int PIX_START_W = 10,
    parameter int PIX_LEN_W   = 11,
    parameter int LINE_W      = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   frame_start,
    input logic [PIX_CNT_W-1:0]   pix_cnt,
    input logic [LINE_W-1:0]      line_cnt,
    input logic [PIX_START_W-1:0] pix_start,
    input logic [PIX_LEN_W-1:0]   pix_len,
    input logic [LINE_W-1:0]      line_start,
    input logic [LINE_W-1:0]      line_len,
    input logic [4:0]             ctrl,
    input logic                   gpo_out,
    input logic                   frame_odd
);
    logic past_ok;
    logic h_ref;
    logic v_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        h_ref = (int'(pix_cnt) >= int'(pix_start)) &&
                (int'(pix_cnt) < int'(pix_start) + int'(pix_len));
        v_ref = (int'(line_cnt) >= int'(line_start)) &&
                (int'(line_cnt) < int'(line_start) + int'(line_len));
    end

    // R7
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(ctrl[4])) |-> !gpo_out);

    // R6
    parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(frame_start)) |-> (frame_odd != $past(frame_odd)));

    // R6
    parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(frame_start)) |-> $stable(frame_odd));

    // R2
    horiz_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctrl) == 5'b10001) |-> (gpo_out == $past(h_ref)));

    // R3
    vert_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctrl) == 5'b10010) |-> (gpo_out == $past(v_ref)));

    // R4
    both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctrl) == 5'b10000) |-> (gpo_out == ($past(h_ref) && $past(v_ref))));
endmodule

bind panel_gpo_gen pcg_checker #(
    .PIX_CNT_W  (PIX_CNT_W),
    .PIX_START_W(PIX_START_W),
    .PIX_LEN_W  (PIX_LEN_W),
    .LINE_W     (LINE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .pix_cnt    (pix_cnt),
    .line_cnt   (line_cnt),
    .pix_start  (pix_start),
    .pix_len    (pix_len),
    .line_start (line_start),
    .line_len   (line_len),
    .ctrl       (ctrl),
    .gpo_out    (gpo_out),
    .frame_odd  (frame_odd)
);

// File: tb/panel_gpo_gen_tb.sv
module panel_gpo_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [9:0]  pix_cnt = '0;
    logic [10:0] line_cnt = '0;
    logic [9:0]  pix_start = '0;
    logic [10:0] pix_len = '0;
    logic [10:0] line_start = '0;
    logic [10:0] line_len = '0;
    logic [4:0]  ctrl = '0;
    logic        gpo_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_odd = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_gpo_gen dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .pix_start(pix_start), .pix_len(pix_len),
        .line_start(line_start), .line_len(line_len),
        .ctrl(ctrl), .gpo_out(gpo_out)
    );

    function automatic bit ref_level();
        bit h, v, m;
        h = (int'(pix_cnt) >= int'(pix_start)) && (int'(pix_cnt) < int'(pix_start) + int'(pix_len));
        v = (int'(line_cnt) >= int'(line_start)) && (int'(line_cnt) < int'(line_start) + int'(line_len));
        case (ctrl[1:0])
            2'd0: m = h && v;
            2'd1: m = h;
            2'd2: m = v;
            default: m = h != v;
        endcase
        if (ctrl[2]) m = !m;
        if (ctrl[3] && model_odd) m = !m;
        if (!ctrl[4]) m = 1'b0;
        return m;
    endfunction

    task automatic compare(input bit exp, input string tag);
        n_cmp++;
        if (gpo_out !== exp) begin
            n_bad++;
            $display("FAIL %s: gpo_out=%0b expected=%0b (pix=%0d line=%0d ctrl=%b)",
                     tag, gpo_out, exp, pix_cnt, line_cnt, ctrl);
        end
    endtask

    // Drives one cycle of inputs (called just after a falling edge), then checks after the next edge
    task automatic step(input int p, input int l, input bit fs, input string tag);
        bit exp;
        pix_cnt = p[9:0];
        line_cnt = l[10:0];
        frame_start = fs;
        exp = ref_level();
        if (fs) model_odd = !model_odd;
        @(negedge clk);
        compare(exp, tag);
    endtask

    task automatic raster(input int frames, input int lines, input int pixels, input string tag);
        for (int f = 0; f < frames; f++)
            for (int l = 0; l < lines; l++)
                for (int p = 0; p < pixels; p++)
                    step(p, l, (l == 0 && p == 0), tag);
    endtask

    task automatic set_regs(input int ps, input int pl, input int ls, input int ll, input logic [4:0] c);
        pix_start = ps[9:0];
        pix_len = pl[10:0];
        line_start = ls[10:0];
        line_len = ll[10:0];
        ctrl = c;
    endtask

    initial begin
        // R1: reset holds the output low even with a window that covers everything
        set_regs(0, 2047, 0, 2047, 5'b10001);
        repeat (3) @(negedge clk);
        compare(1'b0, "R1");
        rst_n = 1'b1;
        model_odd = 1'b0;
        compare(1'b0, "R1");

        // R2 horizontal window edges; R8 one-clock latency is covered by each step
        set_regs(5, 4, 0, 0, 5'b10001);
        for (int p = 0; p < 14; p++) step(p, 3, 1'b0, "R2");
        step(8, 0, 1'b0, "R8");
        step(9, 0, 1'b0, "R8");

        // R3 vertical window edges
        set_regs(0, 0, 3, 2, 5'b10010);
        for (int l = 0; l < 8; l++) step(0, l, 1'b0, "R3");

        // R4 each merge mode over a small raster
        set_regs(2, 3, 1, 3, 5'b10000);
        raster(1, 6, 8, "R4");
        ctrl = 5'b10011;
        raster(1, 6, 8, "R4");

        // R5 inversion
        ctrl = 5'b10100;
        raster(1, 6, 8, "R5");

        // R6 frame alternation over several frames
        ctrl = 5'b11001;
        raster(4, 3, 6, "R6");
        ctrl = 5'b11110;
        raster(3, 3, 4, "R6");

        // R7 disabled output stays low
        set_regs(0, 2047, 0, 2047, 5'b01101);
        raster(2, 3, 4, "R7");

        // R9 zero-length windows
        set_regs(0, 0, 0, 0, 5'b10001);
        for (int p = 0; p < 6; p++) step(p, 0, 1'b0, "R9");
        ctrl = 5'b10010;
        for (int l = 0; l < 6; l++) step(0, l, 1'b0, "R9");

        // R10 window past the top of the pixel range does not wrap
        set_regs(1020, 11, 0, 0, 5'b10001);
        for (int p = 1016; p < 1024; p++) step(p, 0, 1'b0, "R10");
        for (int p = 0; p < 4; p++) step(p, 0, 1'b0, "R10");
        set_regs(0, 0, 2040, 20, 5'b10010);
        step(0, 2047, 1'b0, "R10");
        step(0, 0, 1'b0, "R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule